// File: doc/BRIEF.md
# Dual-Period Watchdog Timer

This block supervises processor activity by watching a watchdog input that may sit high, sit low or float. Three-level sensing happens outside it and arrives as a level bit plus a float-detect bit. While the input is driven and the supply is healthy, the block counts ticks from a timebase enable. If the input does not change level within the current period, the block sends a one-clock time-out strobe to the reset generator. It also pulls its watchdog status output low.

Any level change services the timer, whether rising or falling. Each time the reset generator releases reset, the first interval is a long grace period. The block switches to the shorter normal period after the first level change that follows that release. A period-select input can pin the block to the long period. A floating input disables the timer, and so does a low-supply or battery-backup condition. The low-supply and battery flags also force the status output high.

Top module: `wdog_dual_period`

## Requirements
- R1: A level change on the synchronised watchdog input, rising or falling, clears the tick count. The period starts over, so a change at least once every (period − 1) ticks prevents any time-out.
- R2: After the reset-active flag drops, and before any level change, a time-out occurs after LONG_TICKS ticks with the input steady.
- R3: After the first level change that follows reset release, the period is SHORT_TICKS ticks.
- R4: While `long_only_i` is 1, the period is LONG_TICKS even after level changes.
- R5: `expire_o` goes high in the cycle after the clock edge that samples the Nth tick. It is one clock wide. `wd_ok_o` goes low in that same cycle. It stays low, even across a reset pulse, until the next level change.
- R6: While `wd_float_i` is 1, no time-out is issued. Level changes made while floating are ignored, so they do not switch the block to the short period.
- R7: While `low_line_i` or `batt_mode_i` is 1, no time-out is issued and `wd_ok_o` is 1 from the next cycle on. Counting resumes with a full period when both flags drop.
- R8: While `rst_active_i` is 1, no ticks are counted. Counting begins on the first tick after it drops.
- R9: After a time-out, no further strobe is issued until `rst_active_i` has been asserted again and released.
- R10: After `rst_n`, `expire_o` is 0 and `wd_ok_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Timebase tick enable, one clock wide |
| wd_level_i | input | 1 | Watchdog input level (asynchronous) |
| wd_float_i | input | 1 | Watchdog input detected floating (asynchronous) |
| long_only_i | input | 1 | 1 = always use the long period |
| rst_active_i | input | 1 | Reset generator is holding reset |
| low_line_i | input | 1 | Supply below reset threshold |
| batt_mode_i | input | 1 | Running from backup battery |
| expire_o | output | 1 | One-clock time-out strobe to the reset generator |
| wd_ok_o | output | 1 | Watchdog status, low after a time-out |

## Verification
The bench measures the exact tick count to each strobe at tick spacings of one, two and three clocks. It does this in grace mode, normal mode and forced-long mode, which separates the two periods and checks their switching rule. Servicing sweeps toggle the input in both directions every (period − 1) ticks, which shows that both edge polarities restart the count. Further runs hold the input floating, in reset, in low-supply and in battery mode for several long periods, which separates disabling from mere servicing. They also check that an edge made while floating does not shorten the next period.

// File: rtl/wdt_pkg.sv
// Shared types for the dual-period watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package wdt_pkg;
    // Which time-out period is currently in force
    typedef enum logic {
        PH_GRACE  = 1'b0,
        PH_NORMAL = 1'b1
    } wd_phase_e;
endpackage

// File: rtl/wdt_edge_sync.sv
// Synchronises the watchdog level and float flag and flags level changes.
// Assumes: STAGES >= 2. Changes seen while floating are not reported.
module wdt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic float_i,
    output logic float_s_o,
    output logic edge_o
);
    logic [STAGES-1:0] lvl_sr;
    logic [STAGES-1:0] flt_sr;
    logic              lvl_prev;

    // First stage captures the raw inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_sr[0] <= 1'b0;
            flt_sr[0] <= 1'b1;
        end else begin
            lvl_sr[0] <= level_i;
            flt_sr[0] <= float_i;
        end
    end

    // Remaining stages of the synchroniser chain
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_sr[i] <= 1'b0;
                flt_sr[i] <= 1'b1;
            end else begin
                lvl_sr[i] <= lvl_sr[i-1];
                flt_sr[i] <= flt_sr[i-1];
            end
        end
    end

    // Previous synchronised level, kept current even while floating
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= 1'b0;
        else        lvl_prev <= lvl_sr[STAGES-1];
    end

    // Report a change of either polarity unless floating
    always_comb begin
        float_s_o = flt_sr[STAGES-1];
        edge_o    = (lvl_sr[STAGES-1] ^ lvl_prev) & ~flt_sr[STAGES-1];
    end
endmodule

// File: rtl/wdt_phase_ctl.sv
// Picks the period in force: grace after each reset until the first
// service edge, then normal; a force-long input overrides.
// Assumes: SHORT_TICKS <= LONG_TICKS, both >= 2.
module wdt_phase_ctl
    import wdt_pkg::*;
#(
    parameter int LONG_TICKS  = 4096,
    parameter int SHORT_TICKS = 1024,
    localparam int CW = $clog2(LONG_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rst_active_i,
    input  logic          svc_edge_i,
    input  logic          long_only_i,
    output logic [CW-1:0] period_o
);
    localparam logic [CW-1:0] LONG_V  = CW'(LONG_TICKS);
    localparam logic [CW-1:0] SHORT_V = CW'(SHORT_TICKS);

    wd_phase_e phase;

    // Grace while reset is held; normal after the first edge after release
    always_ff @(posedge clk) begin
        if (!rst_n || rst_active_i) phase <= PH_GRACE;
        else if (svc_edge_i)        phase <= PH_NORMAL;
    end

    // Period select
    always_comb begin
        period_o = (long_only_i || phase == PH_GRACE) ? LONG_V : SHORT_V;
    end
endmodule

// File: rtl/wdt_tick_count.sv
// Counts timebase ticks and raises a one-clock strobe when the count
// reaches the period; then holds cleared until reset is asserted again.
// Assumes: period_i >= 2.
module wdt_tick_count #(
    parameter int LONG_TICKS = 4096,
    localparam int CW = $clog2(LONG_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          clear_i,
    input  logic          rst_active_i,
    input  logic [CW-1:0] period_i,
    output logic          fire_o,
    output logic          expire_o
);
    logic [CW-1:0] count;
    logic          held;

    // Last tick of the period is being sampled this cycle
    always_comb begin
        fire_o = tick_i && !clear_i && !held && (count >= period_i - CW'(1));
    end

    // Tick counter
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || held || fire_o) count <= '0;
        else if (tick_i)                         count <= count + CW'(1);
    end

    // Post-expiry hold, released by the reset generator
    always_ff @(posedge clk) begin
        if (!rst_n || rst_active_i) held <= 1'b0;
        else if (fire_o)            held <= 1'b1;
    end

    // Registered strobe
    always_ff @(posedge clk) begin
        if (!rst_n) expire_o <= 1'b0;
        else        expire_o <= fire_o;
    end
endmodule

// File: rtl/wdog_dual_period.sv
// Dual-period watchdog top: synchronises the input, selects the period,
// counts ticks and drives the strobe and status output.
// Assumes: rst_active_i, low_line_i, batt_mode_i, long_only_i, tick_i are
// synchronous to clk; wd_level_i and wd_float_i may be asynchronous.
module wdog_dual_period #(
    parameter int LONG_TICKS  = 4096,
    parameter int SHORT_TICKS = 1024,
    parameter int SYNC_STAGES = 2,
    localparam int CW = $clog2(LONG_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic wd_level_i,
    input  logic wd_float_i,
    input  logic long_only_i,
    input  logic rst_active_i,
    input  logic low_line_i,
    input  logic batt_mode_i,
    output logic expire_o,
    output logic wd_ok_o
);
    logic          float_s;
    logic          svc_edge;
    logic          supply_bad;
    logic          clear_cnt;
    logic          fire;
    logic [CW-1:0] period;

    wdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .level_i(wd_level_i), .float_i(wd_float_i),
        .float_s_o(float_s), .edge_o(svc_edge)
    );

    wdt_phase_ctl #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_phase (
        .clk(clk), .rst_n(rst_n),
        .rst_active_i(rst_active_i), .svc_edge_i(svc_edge),
        .long_only_i(long_only_i), .period_o(period)
    );

    // Anything that stops or restarts the count
    always_comb begin
        supply_bad = low_line_i | batt_mode_i;
        clear_cnt  = supply_bad | float_s | rst_active_i | svc_edge;
    end

    wdt_tick_count #(.LONG_TICKS(LONG_TICKS)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .tick_i(tick_i), .clear_i(clear_cnt),
        .rst_active_i(rst_active_i), .period_i(period),
        .fire_o(fire), .expire_o(expire_o)
    );

    // Status output: low on expiry, high on service edge or bad supply
    always_ff @(posedge clk) begin
        if (!rst_n)                     wd_ok_o <= 1'b1;
        else if (supply_bad || svc_edge) wd_ok_o <= 1'b1;
        else if (fire)                   wd_ok_o <= 1'b0;
    end
endmodule

// File: rtl/wdog_dual_period_chk.sv
// Property checker for the dual-period watchdog, bound to the top.
// Assumes: sampled on the same clock and reset as the top.
module wdog_dual_period_chk (
    input logic clk,
    input logic rst_n,
    input logic rst_active_i,
    input logic low_line_i,
    input logic batt_mode_i,
    input logic svc_edge,
    input logic expire_o,
    input logic wd_ok_o
);
    // R5
    strobe_one_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);
    // R5
    status_low_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> !wd_ok_o);
    // R7
    supply_forces_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_line_i || batt_mode_i) |=> (wd_ok_o && !expire_o));
    // R8
    no_expiry_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active_i |=> !expire_o);
    // R5
    ok_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_ok_o) |-> $past(low_line_i || batt_mode_i || svc_edge));
endmodule

bind wdog_dual_period wdog_dual_period_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .rst_active_i(rst_active_i), .low_line_i(low_line_i),
    .batt_mode_i(batt_mode_i), .svc_edge(svc_edge),
    .expire_o(expire_o), .wd_ok_o(wd_ok_o)
);

// File: tb/sim_wdog_dual_period.sv
module sim_wdog_dual_period;
    localparam int LONG  = 16;
    localparam int SHORT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0;
    logic wd_level_i = 1'b0;
    logic wd_float_i = 1'b0;
    logic long_only_i = 1'b0;
    logic rst_active_i = 1'b0;
    logic low_line_i = 1'b0;
    logic batt_mode_i = 1'b0;
    logic expire_o;
    logic wd_ok_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdog_dual_period #(.LONG_TICKS(LONG), .SHORT_TICKS(SHORT)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .wd_level_i(wd_level_i), .wd_float_i(wd_float_i),
        .long_only_i(long_only_i), .rst_active_i(rst_active_i),
        .low_line_i(low_line_i), .batt_mode_i(batt_mode_i),
        .expire_o(expire_o), .wd_ok_o(wd_ok_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int k);
        tick_i = 1'b0;
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic toggle();
        wd_level_i = ~wd_level_i;
        idle(4);
    endtask

    task automatic pulse_reset();
        rst_active_i = 1'b1;
        idle(3);
        rst_active_i = 1'b0;
    endtask

    // Expect a strobe exactly when the Nth tick has been sampled
    task automatic measure(input int exp_n, input int div, input string req);
        int n = 0;
        int got = -1;
        for (int c = 0; c < (exp_n + 2) * div + 4; c++) begin
            tick_i = (c % div) == 0;
            @(negedge clk);
            if (tick_i) n++;
            if (expire_o) begin got = n; break; end
        end
        tick_i = 1'b0;
        chk(got == exp_n, req, got, exp_n);
        if (got == exp_n) begin
            chk(wd_ok_o == 1'b0, "R5 status low", wd_ok_o, 0);
            @(negedge clk);
            chk(expire_o == 1'b0, "R5 one wide", expire_o, 0);
        end
    endtask

    // Expect no strobe over the given number of ticks
    task automatic quiet(input int ticks, input int div, input string req);
        int seen = 0;
        for (int c = 0; c < ticks * div; c++) begin
            tick_i = (c % div) == 0;
            @(negedge clk);
            if (expire_o) seen++;
        end
        tick_i = 1'b0;
        chk(seen == 0, req, seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(expire_o == 1'b0, "R10 expire", expire_o, 0);
        chk(wd_ok_o == 1'b1, "R10 wd_ok", wd_ok_o, 1);
        rst_n = 1'b1;
        idle(2);

        for (int div = 1; div <= 3; div++) begin
            // R2 grace period after release
            pulse_reset();
            measure(LONG, div, "R2 grace period");
            // R9 no repeat strobe until reset asserted again
            quiet(3 * LONG, div, "R9 held after expiry");
            // R5 status stays low across reset, edge sets it
            pulse_reset();
            chk(wd_ok_o == 1'b0, "R5 low across reset", wd_ok_o, 0);
            toggle();
            chk(wd_ok_o == 1'b1, "R5 edge sets high", wd_ok_o, 1);
            // R1 both polarities service the timer
            for (int r = 0; r < 6; r++) begin
                quiet(SHORT - 1, div, "R1 serviced");
                toggle();
            end
            // R3 short period after first edge
            measure(SHORT, div, "R3 normal period");
            // R4 force long
            pulse_reset();
            toggle();
            long_only_i = 1'b1;
            measure(LONG, div, "R4 forced long");
            long_only_i = 1'b0;
        end

        // R6 floating disables and hides edges
        pulse_reset();
        wd_float_i = 1'b1;
        idle(4);
        quiet(3 * LONG, 1, "R6 float disables");
        toggle();
        wd_float_i = 1'b0;
        idle(4);
        measure(LONG, 1, "R6 edge while floating ignored");

        // R7 low supply
        pulse_reset();
        low_line_i = 1'b1;
        @(negedge clk);
        chk(wd_ok_o == 1'b1, "R7 low line sets ok", wd_ok_o, 1);
        quiet(3 * LONG, 1, "R7 low line disables");
        low_line_i = 1'b0;
        measure(LONG, 1, "R7 resume after low line");

        // R7 battery mode
        pulse_reset();
        batt_mode_i = 1'b1;
        @(negedge clk);
        chk(wd_ok_o == 1'b1, "R7 battery sets ok", wd_ok_o, 1);
        quiet(3 * LONG, 2, "R7 battery disables");
        batt_mode_i = 1'b0;
        measure(LONG, 2, "R7 resume after battery");

        // R8 no counting while reset held
        rst_active_i = 1'b1;
        quiet(3 * LONG, 1, "R8 reset held");
        rst_active_i = 1'b0;
        measure(LONG, 1, "R8 restart on release");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule